// File: doc/BRIEF.md
# Real-Time Clock Update and Periodic Timebase

This block turns a stream of reference ticks into the timing events a real-time clock needs. It expects one single-cycle `ref_tick` per period of the nominal 32.768 kHz reference, synchronous to the system clock `clk`. A counter of 2^SEC_LOG2 ticks marks each second. Each second produces one update strobe for the calendar logic and an update-in-progress status flag that brackets that strobe. When the flag drops, a one-cycle update-finished pulse follows. A separate power-of-two divider produces a programmable periodic tick.

An 8-bit rate/divider register configures the block.
- Bits 3:0 hold the periodic rate code.
- Bits 6:4 form the divider control field.
- Bit 7 reads back the live update-in-progress flag and cannot be written.

The interrupt flag logic and the calendar counters sit outside this block. They consume `upd_strobe`, `upd_done` and `pi_tick`.

Top module: `rtc_timebase`

## Requirements
- R1: After synchronous reset, `cfg_rdata` reads 8'h00, and `uip`, `upd_strobe`, `upd_done` and `pi_tick` are all 0.
- R2: A write with `cfg_we` high stores `cfg_wdata[6:0]`, which is visible in `cfg_rdata[6:0]` from the next cycle. `cfg_wdata[7]` is ignored. `cfg_rdata[7]` always shows the `uip` flag.
- R3: While the divider runs, `upd_strobe` pulses for exactly one cycle once every 2^SEC_LOG2 reference ticks. The pulse appears in the cycle after the tick that completes the second.
- R4: `uip` rises UIP_LEAD ticks before each update strobe. It falls UIP_TICKS - UIP_LEAD ticks after that strobe, so every strobe lies inside the window where `uip` is high.
- R5: `upd_done` pulses for one cycle in the same cycle in which `uip` goes from 1 to 0 because its window ended.
- R6: Let n be the rate code in bits 3:0. If n is nonzero, `pi_tick` pulses once every 2^(n-1) reference ticks, so code 1 fires on every tick and code 15 fires every 16384 ticks. If n is 0, `pi_tick` never pulses.
- R7: A write that changes the rate code from 0 to a nonzero n gives the first `pi_tick` on the 2^(n-1)-th reference tick after the write cycle.
- R8: While bits 6:5 of the register are both 1 (divider field 3'b110 or 3'b111), the second and periodic counters are held at zero and `uip` is held at 0. No `upd_strobe`, `upd_done` or `pi_tick` is produced. Any other field value runs the divider, and 3'b010 is the normal setting.
- R9: After the divider field leaves the hold values, the first `upd_strobe` follows the 2^SEC_LOG2-th reference tick after the write cycle.
- R10: Cycles without `ref_tick` advance no counter and produce no `upd_strobe`, `upd_done` or `pi_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| cfg_we | input | 1 | Write enable for the rate/divider register |
| cfg_wdata | input | 8 | Write data; bit 7 ignored |
| cfg_rdata | output | 8 | Readback: {uip, divider field, rate code} |
| uip | output | 1 | Update-in-progress flag |
| upd_strobe | output | 1 | One-cycle strobe that advances the calendar |
| upd_done | output | 1 | One-cycle pulse when the update window closes |
| pi_tick | output | 1 | One-cycle periodic tick |

## Verification
The hardest situation to reach is a register write that lands in the middle of a count. Examples are a hold or a release while the update window is open, or a rate change while the periodic divider is mid-period. Only the ports reveal the exact phase of both counters.

The bench runs long stretches with reference ticks that arrive at random. It writes random divider field values and rate codes at random moments, biased toward the running setting with occasional hold values. A bench model counts ticks against the requirements and predicts every output in every cycle.

Directed sequences then pin down three cases exactly:
- the first periodic tick after enabling a rate;
- the first update after leaving hold;
- complete silence during hold and during tick gaps.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

  localparam int RATE_W = 4;
  localparam int DIV_W  = 3;
  localparam int CFG_W  = RATE_W + DIV_W;
  localparam int PER_W  = (1 << RATE_W) - 2;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [RATE_W-1:0] rate;
  } cfg_t;

  // Low bits of the periodic counter that must all be ones for a tick.
  function automatic logic [PER_W-1:0] rate_mask(input logic [RATE_W-1:0] code);
    if (code == '0) return '0;
    return (PER_W'(1) << (code - RATE_W'(1))) - PER_W'(1);
  endfunction

endpackage

// File: rtl/rtcb_cfg_reg.sv
module rtcb_cfg_reg
  import rtcb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg,
  output logic             hold
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= '0;
      hold <= 1'b0;
    end else if (we) begin
      cfg  <= cfg_t'(wdata);
      hold <= (wdata[CFG_W-1 -: 2] == 2'b11);
    end
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (cfg == $past(wdata)));

endmodule

// File: rtl/rtcb_sec_div.sv
module rtcb_sec_div #(
  parameter int SEC_LOG2  = 15,
  parameter int UIP_TICKS = 73,
  parameter int UIP_LEAD  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic ref_tick,
  output logic uip,
  output logic upd_strobe,
  output logic upd_done
);

  localparam int SEC  = 1 << SEC_LOG2;
  localparam int TAIL = UIP_TICKS - UIP_LEAD;
  localparam logic [SEC_LOG2-1:0] LAST_C  = SEC_LOG2'(SEC - 1);
  localparam logic [SEC_LOG2-1:0] RISE_C  = SEC_LOG2'(SEC - UIP_LEAD - 1);
  localparam logic [SEC_LOG2-1:0] FALL_C  = SEC_LOG2'(TAIL - 1);

  logic [SEC_LOG2-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt        <= '0;
      uip        <= 1'b0;
      upd_strobe <= 1'b0;
      upd_done   <= 1'b0;
    end else begin
      upd_strobe <= 1'b0;
      upd_done   <= 1'b0;
      if (ref_tick) begin
        cnt <= cnt + SEC_LOG2'(1);
        if (cnt == LAST_C) upd_strobe <= 1'b1;
        if (cnt == RISE_C) begin
          uip <= 1'b1;
        end else if (uip && cnt == FALL_C) begin
          uip      <= 1'b0;
          upd_done <= 1'b1;
        end
      end
    end
  end

  assert_strobe_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> uip);

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |=> !upd_strobe);

  assert_done_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    upd_done |-> (!uip && $past(uip)));

  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> (!upd_strobe && !upd_done && !uip));

  assert_strobe_needs_ref_R10: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |-> $past(ref_tick));

endmodule

// File: rtl/rtcb_periodic.sv
module rtcb_periodic
  import rtcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              ref_tick,
  input  logic [RATE_W-1:0] code,
  output logic              pi_tick
);

  logic [PER_W-1:0] pcnt;
  logic [PER_W-1:0] mask;
  logic             hit;

  assign mask = rate_mask(code);
  assign hit  = &(pcnt | ~mask);

  always_ff @(posedge clk) begin
    if (rst || hold || code == '0) begin
      pcnt    <= '0;
      pi_tick <= 1'b0;
    end else begin
      pi_tick <= 1'b0;
      if (ref_tick) begin
        pcnt    <= pcnt + PER_W'(1);
        pi_tick <= hit;
      end
    end
  end

  assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    $past(code == '0) |-> !pi_tick);

  assert_tick_needs_ref_R10: assert property (@(posedge clk) disable iff (rst)
    pi_tick |-> $past(ref_tick));

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtcb_pkg::*;
#(
  parameter int SEC_LOG2  = 15,
  parameter int UIP_TICKS = 73,
  parameter int UIP_LEAD  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       uip,
  output logic       upd_strobe,
  output logic       upd_done,
  output logic       pi_tick
);

  cfg_t cfg;
  logic hold;
  logic unused_ro_bit;

  // Bit 7 is a status bit: writes to it have no effect.
  assign unused_ro_bit = cfg_wdata[7];

  rtcb_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata[CFG_W-1:0]),
    .cfg   (cfg),
    .hold  (hold)
  );

  rtcb_sec_div #(
    .SEC_LOG2  (SEC_LOG2),
    .UIP_TICKS (UIP_TICKS),
    .UIP_LEAD  (UIP_LEAD)
  ) u_sec (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .ref_tick   (ref_tick),
    .uip        (uip),
    .upd_strobe (upd_strobe),
    .upd_done   (upd_done)
  );

  rtcb_periodic u_per (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .ref_tick (ref_tick),
    .code     (cfg.rate),
    .pi_tick  (pi_tick)
  );

  assign cfg_rdata = {uip, cfg};

endmodule

// File: tb/rtc_timebase_bench.sv
`timescale 1ns/1ps
module rtc_timebase_bench;

  localparam int SEC_LOG2  = 10;
  localparam int UIP_TICKS = 20;
  localparam int UIP_LEAD  = 4;
  localparam int SEC  = 1 << SEC_LOG2;
  localparam int TAIL = UIP_TICKS - UIP_LEAD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       uip, upd_strobe, upd_done, pi_tick;

  int n_checks = 0;
  int n_failed = 0;
  int cyc = 0;
  bit model_on = 1'b0;

  // bench model state
  logic [6:0] m_cfg;
  int  m_sec, m_p;
  bit  m_uip, e_upd, e_done, e_pi;

  always #2.5 clk = ~clk;

  rtc_timebase #(
    .SEC_LOG2 (SEC_LOG2), .UIP_TICKS (UIP_TICKS), .UIP_LEAD (UIP_LEAD)
  ) u_rtc_timebase (
    .clk (clk), .rst (rst), .ref_tick (ref_tick),
    .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
    .uip (uip), .upd_strobe (upd_strobe), .upd_done (upd_done),
    .pi_tick (pi_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_failed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit is_hold(input logic [6:0] c);
    return c[6:5] == 2'b11;
  endfunction

  // Requirement-based prediction, advanced on every rising edge.
  always @(posedge clk) begin
    if (rst) begin
      m_cfg = '0; m_sec = 0; m_p = 0; m_uip = 0;
      e_upd = 0; e_done = 0; e_pi = 0;
    end else begin
      e_upd = 0; e_done = 0; e_pi = 0;
      if (is_hold(m_cfg)) begin
        m_sec = 0; m_p = 0; m_uip = 0;
      end else begin
        if (m_cfg[3:0] == 0) m_p = 0;
        if (ref_tick) begin
          m_sec = m_sec + 1;
          if (m_sec == SEC) begin m_sec = 0; e_upd = 1; end
          if (m_sec == SEC - UIP_LEAD) m_uip = 1;
          else if (m_uip && m_sec == TAIL) begin m_uip = 0; e_done = 1; end
          if (m_cfg[3:0] != 0) begin
            m_p = m_p + 1;
            if (m_p % (1 << (m_cfg[3:0] - 1)) == 0) e_pi = 1;
          end
        end
      end
      if (cfg_we) m_cfg = cfg_wdata[6:0];
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(cfg_rdata == {m_uip, m_cfg}, "R2 readback", cfg_rdata, {m_uip, m_cfg});
      chk(uip == m_uip, "R4 uip", uip, m_uip);
      chk(upd_strobe == e_upd, "R3 upd_strobe", upd_strobe, e_upd);
      chk(upd_done == e_done, "R5 upd_done", upd_done, e_done);
      chk(pi_tick == e_pi, "R6 pi_tick", pi_tick, e_pi);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_checks++;
      n_failed++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_failed);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(cfg_rdata == 8'h00, "R1 rdata", cfg_rdata, 0);
    chk({uip, upd_strobe, upd_done, pi_tick} == 4'b0, "R1 outputs",
        {uip, upd_strobe, upd_done, pi_tick}, 0);
    model_on = 1'b1;

    // R2: bit 7 write ignored
    wr(8'hA5);
    chk(cfg_rdata == 8'h25, "R2 bit7 ignored", cfg_rdata, 8'h25);

    // R7: code 0 -> 3, first tick after 4 reference ticks
    ref_tick = 1'b1;
    wr(8'h20);
    repeat (5) @(negedge clk);
    wr(8'h23);
    cnt = 1;
    while (!pi_tick && cnt < 50) begin @(negedge clk); cnt++; end
    chk(cnt == 5, "R7 first periodic tick", cnt, 5);

    // R8: hold with code 1, nothing may come out
    wr(8'h71);
    cnt = 0;
    for (int i = 0; i < 2 * SEC; i++) begin
      @(negedge clk);
      if (upd_strobe || upd_done || pi_tick || uip) cnt++;
    end
    chk(cnt == 0, "R8 hold silent", cnt, 0);

    // R9: release, first update one second later
    wr(8'h21);
    cnt = 1;
    while (!upd_strobe && cnt < 3 * SEC) begin @(negedge clk); cnt++; end
    chk(cnt == SEC + 1, "R9 first update after release", cnt, SEC + 1);

    // R10: no reference ticks, no events
    ref_tick = 1'b0;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (upd_strobe || upd_done || pi_tick) cnt++;
    end
    chk(cnt == 0, "R10 no ticks no events", cnt, 0);

    // Random phase
    for (int i = 0; i < 30000; i++) begin
      ref_tick = ($urandom % 4) != 0;
      if ($urandom % 300 == 0) begin
        int sel;
        logic [2:0] dv;
        sel = $urandom % 10;
        if (sel < 8) dv = 3'b010;
        else if (sel == 8) dv = 3'b110 | 3'($urandom % 2);
        else dv = 3'($urandom % 6);
        cfg_we = 1'b1;
        cfg_wdata = {1'($urandom % 2), dv, 4'($urandom % 12)};
      end else begin
        cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_failed);
    $finish;
  end

endmodule